// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block turns a crystal oscillator and the PLL that follows it on or off by driving two general-purpose pin registers, an output value and an output enable. It reads a third register, the sensed pin inputs, to see whether the crystal is already running. Each command carries a bit mask and an on/off flag. Mask bit `XTAL_BIT` selects the crystal and mask bit `PLL_BIT` selects the PLL. The sequencer then applies its register updates one per clock in a fixed order. It inserts settle waits counted in milliseconds and raises `done` for one cycle when it finishes.

The PLL control bit is active low. A 1 on `gpio_out[PLL_BIT]` holds the PLL off and a 0 lets it run. During a power-up the PLL is kept off while the crystal settles, and it is released only after that. If the crystal already reads as running when the command is accepted, the bring-up steps are all skipped so that a clock another consumer may be using does not glitch. A 16-bit status register accumulates event bits from `status_set`. Every power-up command clears its signalled-target-abort flag (bit `STA_BIT`, default 11). The millisecond waits come from one shared down-counter sized by `CYC_PER_MS`.

Top module: `xtal_pll_seq`

## Requirements
- R1: After reset, `gpio_out`, `gpio_oe` and `status` are all zero, and `busy` and `done` are low.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` stays high from the next cycle until the cycle after `done`. A `cmd_valid` seen while `busy` is high has no effect on the outputs.
- R3: `done` is high for exactly one cycle at the end of every accepted command, and only while `busy` is high.
- R4: A write to `gpio_oe` sets it to `gpio_oe | mask` for every bit of the accepted mask, so it never loses a bit. It is written only by power-down and by a crystal power-up. Mask bits other than `XTAL_BIT` and `PLL_BIT` never change `gpio_out`.
- R5: A power-up command accepted while `gpio_in[XTAL_BIT]` is 1 leaves `gpio_out` and `gpio_oe` unchanged.
- R6: Crystal power-up sets `gpio_out[XTAL_BIT]`, and also sets `gpio_out[PLL_BIT]` if the PLL is requested. It writes `gpio_oe` one cycle later and then waits `CYC_PER_MS` cycles, during which the PLL bit stays high.
- R7: PLL power-up clears `gpio_out[PLL_BIT]` after any crystal step and its wait, and then waits `2*CYC_PER_MS` cycles.
- R8: Every power-up command, skipped or not, clears `status[STA_BIT]` after its steps. Otherwise, each `status` bit is set when the matching `status_set` bit is high, and a clear in the same cycle wins over a set.
- R9: Power-down clears `gpio_out[XTAL_BIT]` if the crystal is requested and sets `gpio_out[PLL_BIT]` if the PLL is requested. It writes `gpio_oe` in the next cycle, has no wait and leaves `status` untouched.
- R10: Counting clock edges after the accepting edge, `done` is first seen after edge 2 for power-down. For power-up it is seen after edge 1 + (crystal step ? 2+N : 0) + (PLL step ? 1+2N : 0), where N = `CYC_PER_MS` and both steps are dropped when skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_on | input | 1 | 1 = power up, 0 = power down |
| cmd_mask | input | GPIO_W | Request mask (crystal, PLL, other enable bits) |
| gpio_in | input | GPIO_W | Sensed pin inputs; only `XTAL_BIT` is used |
| status_set | input | 16 | Event bits OR-ed into the status register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| gpio_out | output | GPIO_W | Pin output value register |
| gpio_oe | output | GPIO_W | Pin output-enable register |
| status | output | 16 | Status register |

## Verification
The assertions assume that `gpio_in[XTAL_BIT]` is already synchronous to `clk`. They also assume that `status_set` never tries to set the abort flag in the cycle the sequencer clears it. The bench therefore changes `gpio_in` and pulses `status_set` only while the block is idle, and it holds both steady across each command. Stray requests are injected only while `busy` is high, so the checker can attribute every register change to the accepted command.

// File: rtl/xps_pkg.sv
package xps_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_XOUT,
        S_XOE,
        S_XWAIT,
        S_POUT,
        S_PWAIT,
        S_DOUT,
        S_DOE,
        S_STAT,
        S_DONE
    } xps_state_e;

    // One register action per cycle, decoded from the sequencer state.
    typedef struct packed {
        logic xtal_sel;   // crystal requested by accepted command
        logic pll_sel;    // PLL requested by accepted command
        logic set_xtal;   // raise crystal bit (and PLL-off if pll_sel)
        logic clr_pll;    // release PLL (active-low control)
        logic down;       // power-down output update
        logic oe_write;   // OR mask into output enable
        logic clr_status; // clear target-abort flag
    } xps_step_t;

    function automatic int unsigned tmr_width(input int unsigned cyc_per_ms);
        return $clog2(2 * cyc_per_ms + 1);
    endfunction

endpackage

// File: rtl/xps_timer.sv
module xps_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == TW'(1));
endmodule

// File: rtl/xps_ctrl.sv
module xps_ctrl
    import xps_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 200000,
    parameter int unsigned TW         = tmr_width(CYC_PER_MS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_on,
    input  logic          want_xtal,
    input  logic          want_pll,
    input  logic          xtal_sensed,
    input  logic          tmr_last,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output xps_step_t     step,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val
);
    localparam logic [TW-1:0] TICKS_1MS = TW'(CYC_PER_MS);
    localparam logic [TW-1:0] TICKS_2MS = TW'(2 * CYC_PER_MS);

    xps_state_e st_q, st_d;
    logic       xsel_q, psel_q;

    assign accept = cmd_valid && (st_q == S_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (!cmd_on)         st_d = S_DOUT;
                    else if (xtal_sensed) st_d = S_STAT;
                    else if (want_xtal)  st_d = S_XOUT;
                    else if (want_pll)   st_d = S_POUT;
                    else                 st_d = S_STAT;
                end
            end
            S_XOUT:  st_d = S_XOE;
            S_XOE:   st_d = S_XWAIT;
            S_XWAIT: if (tmr_last) st_d = psel_q ? S_POUT : S_STAT;
            S_POUT:  st_d = S_PWAIT;
            S_PWAIT: if (tmr_last) st_d = S_STAT;
            S_DOUT:  st_d = S_DOE;
            S_DOE:   st_d = S_DONE;
            S_STAT:  st_d = S_DONE;
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            xsel_q <= 1'b0;
            psel_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                xsel_q <= want_xtal;
                psel_q <= want_pll;
            end
        end
    end

    always_comb begin
        step            = '0;
        step.xtal_sel   = xsel_q;
        step.pll_sel    = psel_q;
        step.set_xtal   = (st_q == S_XOUT);
        step.clr_pll    = (st_q == S_POUT);
        step.down       = (st_q == S_DOUT);
        step.oe_write   = (st_q == S_XOE) || (st_q == S_DOE);
        step.clr_status = (st_q == S_STAT);
    end

    assign tmr_load = (st_q == S_XOE) || (st_q == S_POUT);
    assign tmr_val  = (st_q == S_POUT) ? TICKS_2MS : TICKS_1MS;
    assign busy     = (st_q != S_IDLE);
    assign done     = (st_q == S_DONE);
endmodule

// File: rtl/xps_regs.sv
module xps_regs
    import xps_pkg::*;
#(
    parameter int unsigned GPIO_W   = 8,
    parameter int unsigned XTAL_BIT = 6,
    parameter int unsigned PLL_BIT  = 7,
    parameter int unsigned STA_W    = 16,
    parameter int unsigned STA_BIT  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [GPIO_W-1:0] cmd_mask,
    input  xps_step_t         step,
    input  logic [STA_W-1:0]  status_set,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_oe,
    output logic [STA_W-1:0]  status
);
    localparam logic [STA_W-1:0] STA_CLR = STA_W'(1) << STA_BIT;

    logic [GPIO_W-1:0] mask_q;
    logic [GPIO_W-1:0] out_q, oe_q;
    logic [STA_W-1:0]  sta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            out_q  <= '0;
            oe_q   <= '0;
            sta_q  <= '0;
        end else begin
            if (accept) mask_q <= cmd_mask;
            if (step.set_xtal) begin
                out_q[XTAL_BIT] <= 1'b1;
                if (step.pll_sel) out_q[PLL_BIT] <= 1'b1;
            end
            if (step.clr_pll) out_q[PLL_BIT] <= 1'b0;
            if (step.down) begin
                if (step.xtal_sel) out_q[XTAL_BIT] <= 1'b0;
                if (step.pll_sel)  out_q[PLL_BIT]  <= 1'b1;
            end
            if (step.oe_write) oe_q <= oe_q | mask_q;
            sta_q <= (sta_q | status_set) & ~(step.clr_status ? STA_CLR : '0);
        end
    end

    assign gpio_out = out_q;
    assign gpio_oe  = oe_q;
    assign status   = sta_q;
endmodule

// File: rtl/xtal_pll_seq.sv
module xtal_pll_seq
    import xps_pkg::*;
#(
    parameter int unsigned GPIO_W     = 8,
    parameter int unsigned XTAL_BIT   = 6,
    parameter int unsigned PLL_BIT    = 7,
    parameter int unsigned STA_BIT    = 11,
    parameter int unsigned CYC_PER_MS = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_on,
    input  logic [GPIO_W-1:0] cmd_mask,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic [15:0]       status_set,
    output logic              busy,
    output logic              done,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_oe,
    output logic [15:0]       status
);
    localparam int unsigned TW = tmr_width(CYC_PER_MS);

    logic          accept, tmr_load, tmr_last;
    logic [TW-1:0] tmr_val;
    xps_step_t     step;
    logic          unused_in;

    assign unused_in = ^gpio_in;

    xps_ctrl #(.CYC_PER_MS(CYC_PER_MS), .TW(TW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_on     (cmd_on),
        .want_xtal  (cmd_mask[XTAL_BIT]),
        .want_pll   (cmd_mask[PLL_BIT]),
        .xtal_sensed(gpio_in[XTAL_BIT]),
        .tmr_last   (tmr_last),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .step       (step),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    xps_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    xps_regs #(
        .GPIO_W(GPIO_W), .XTAL_BIT(XTAL_BIT), .PLL_BIT(PLL_BIT),
        .STA_W(16), .STA_BIT(STA_BIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd_mask  (cmd_mask),
        .step      (step),
        .status_set(status_set),
        .gpio_out  (gpio_out),
        .gpio_oe   (gpio_oe),
        .status    (status)
    );
endmodule

// File: rtl/xps_chk.sv
module xps_chk #(
    parameter int unsigned GPIO_W  = 8,
    parameter int unsigned STA_BIT = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [GPIO_W-1:0] gpio_out,
    input logic [GPIO_W-1:0] gpio_oe,
    input logic [15:0]       status
);
    // R3: completion pulse lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: completion only inside a command
    p_done_busy_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R2: an idle sequencer leaves the pin registers alone
    p_out_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(gpio_out));

    p_oe_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(gpio_oe));

    // R4: output enable only gains bits
    p_oe_grows_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gpio_oe & $past(gpio_oe)) == $past(gpio_oe)));

    // R8: abort flag is cleared only by a running command
    p_sta_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(status[STA_BIT]) |-> $past(busy));
endmodule

bind xtal_pll_seq xps_chk #(.GPIO_W(GPIO_W), .STA_BIT(STA_BIT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .gpio_out(gpio_out),
    .gpio_oe (gpio_oe),
    .status  (status)
);

// File: tb/test_xtal_pll_seq.sv
module test_xtal_pll_seq;
    localparam int W  = 8;
    localparam int XB = 6;
    localparam int PB = 7;
    localparam int SB = 11;
    localparam int N  = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_on = 1'b0;
    logic [W-1:0] cmd_mask = '0;
    logic [W-1:0] gpio_in = '0;
    logic [15:0]  status_set = '0;
    logic         busy, done;
    logic [W-1:0] gpio_out, gpio_oe;
    logic [15:0]  status;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_out = '0;
    logic [W-1:0] m_oe  = '0;
    logic [15:0]  m_sta = '0;

    always #2.5 clk = ~clk;

    xtal_pll_seq #(.GPIO_W(W), .XTAL_BIT(XB), .PLL_BIT(PB), .STA_BIT(SB),
                   .CYC_PER_MS(N)) i_xtal_pll_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
        .cmd_mask(cmd_mask), .gpio_in(gpio_in), .status_set(status_set),
        .busy(busy), .done(done), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    task automatic run_cmd(input logic on, input logic [W-1:0] mask,
                           input logic sensed, input logic [15:0] sta_pat,
                           input logic inject);
        logic x, p, skip;
        logic [W-1:0] old_oe, first_out, fin_out, fin_oe;
        int exp_k, k;
        x = mask[XB];
        p = mask[PB];
        skip = on && sensed;
        @(negedge clk);
        gpio_in = W'(sensed) << XB;
        status_set = sta_pat;
        @(negedge clk);
        status_set = '0;
        m_sta = m_sta | sta_pat;
        check("R8 status set", status, m_sta);
        old_oe = m_oe;
        if (!on) begin
            first_out = m_out;
            if (x) first_out[XB] = 1'b0;
            if (p) first_out[PB] = 1'b1;
            fin_out = first_out;
            fin_oe = m_oe | mask;
            exp_k = 2;
        end else if (skip) begin
            first_out = m_out; fin_out = m_out; fin_oe = m_oe; exp_k = 1;
        end else begin
            first_out = m_out;
            if (x) begin
                first_out[XB] = 1'b1;
                if (p) first_out[PB] = 1'b1;
            end
            fin_out = first_out;
            if (p) fin_out[PB] = 1'b0;
            fin_oe = x ? (m_oe | mask) : m_oe;
            exp_k = 1 + (x ? 2 + N : 0) + (p ? 1 + 2 * N : 0);
        end
        cmd_valid = 1'b1; cmd_on = on; cmd_mask = mask;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        k = 0;
        while (k < 100) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (inject && k == 2) begin
                cmd_valid = 1'b1; cmd_on = ~on; cmd_mask = '1;
            end
            if (inject && k == 3) cmd_valid = 1'b0;
            if (k == 1) check("R2 busy after accept", busy, 1);
            if ((!on || (x && !skip)) && k == 1) begin
                check("R6/R9 out written first", gpio_out, first_out);
                check("R4 oe not yet written", gpio_oe, old_oe);
            end
            if ((!on || (x && !skip)) && k == 2)
                check("R4 oe written second", gpio_oe, fin_oe);
            if (on && !skip && x && p && k == 2 + N)
                check("R6 PLL held off through crystal wait", gpio_out[PB], 1);
            if (on && !skip && x && p && k == 3 + N)
                check("R7 PLL released after crystal wait", gpio_out[PB], 0);
            if (done) break;
        end
        check("R10 latency to done", k, exp_k);
        m_out = fin_out;
        m_oe = fin_oe;
        if (on) m_sta[SB] = 1'b0;
        check("R5/R6/R7/R9 final out", gpio_out, m_out);
        check("R4 final oe", gpio_oe, m_oe);
        check("R8 final status", status, m_sta);
        @(negedge clk);
        check("R3 done one cycle", done, 0);
        check("R2 idle after done", busy, 0);
        check("R2 stray request ignored", gpio_out, m_out);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out", gpio_out, 0);
        check("R1 reset oe", gpio_oe, 0);
        check("R1 reset status", status, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out after release", gpio_out, 0);
        for (int it = 0; it < 32; it++) begin
            logic on_b, s_b, inj;
            logic [1:0] xp;
            logic [W-1:0] mk;
            on_b = it[0];
            xp   = it[2:1];
            s_b  = it[3];
            mk   = (W'(xp[0]) << XB) | (W'(xp[1]) << PB) | (W'(it * 5) & 8'h3F);
            inj  = on_b && !s_b && (xp == 2'b11);
            run_cmd(on_b, mk, s_b, 16'h0800 | 16'(it << 2), inj);
        end
        report();
    end
endmodule